// File: doc/BRIEF.md
# Serial Flash Byte-at-a-Time Read Sequencer

This block reads a serial NOR flash one byte per command. Software loads a 32-bit start address into four byte-wide address registers once. It picks the wire mode and stores the read opcode in an opcode register. Each start command then runs one complete chip-select frame on the SPI pins: an opcode phase, an address phase, an optional dummy phase and an 8-bit data phase. When the frame ends, the byte sits in a read-data register and the address pointer has moved on by one. Repeated commands therefore walk through consecutive flash bytes.

There are four read modes, selected by a 4-bit wire-mode register and a fast-read bit. Plain mode uses a fixed opcode and no dummy clocks. Fast, dual and quad modes take their opcode from a register that depends on the mode, and they insert dummy clocks. Dual and quad modes can also carry the address over two or four wires. The serial clock runs at half the system clock. The address phase is 24 bits by default; a parameter widens it to 32 bits, which also sends the top address register.

Top module: `sfr_byte_reader`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sck` is low and `spi_io_oe` is 0, and every register reads back 0.
- R2: The address pointer bits 7:0, 15:8 and 23:16 are at offsets 0x10, 0x14 and 0x18, and bits 31:24 are at 0xC8. All four read back what was written, and a 24-bit frame sends only bits 23:0.
- R3: When the block is idle, writing 0x81 to offset 0x00 starts one read frame. While the frame runs, offset 0x00 reads 0x01, and it reads 0x00 once the frame is over. Writing any other value to 0x00 starts nothing.
- R4: The opcode goes out MSB first on `spi_io_out[0]` with output enable 4'b0001. Each SCK period lasts two clock cycles (low, then high), and data is sampled at the end of the high cycle. A frame of B SCK periods holds `spi_cs_n` low for exactly 2*B cycles.
- R5: When the wire-mode register (0xCC) is 0 and bit 0 of 0x60 is 0, the opcode is 0x03. The frame has 24 address bits on io0, no dummy clocks, and 8 data bits on io1.
- R6: When bit 0 of 0x60 is 1 and 0xCC is 0, the opcode comes from offset 0x2C. The frame has 8 dummy clocks after the address, and the data arrives on io1.
- R7: When bit 0 of 0xCC is 1 (and bit 2 is 0), the opcode comes from 0x2C and the frame has 8 dummy clocks. Data arrives two bits per clock on io1:io0, with io1 more significant. If bit 1 of 0xCC is also set, the address goes out two bits per clock the same way.
- R8: When bit 2 of 0xCC is 1, the opcode comes from 0x30 and the frame has 8 dummy clocks. Data arrives four bits per clock on io3..io0, with io3 most significant. If bit 3 is set, the address also uses four wires. Mode priority is quad, then dual, then fast.
- R9: After each frame, offset 0x0C holds the received byte and the 32-bit address pointer has increased by one, with the carry running through all four address bytes.
- R10: Register writes made while a frame runs are ignored, including a write that lands on the frame's final edge. At that edge the address increment wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_out | output | 4 | Serial data out lanes io3..io0 |
| spi_io_oe | output | 4 | Per-lane output enable |
| spi_io_in | input | 4 | Serial data in lanes io3..io0 |

## Verification
Two things can fall on the same clock edge: the final data beat, which stores the byte and advances the address pointer, and a register write from software. The bench counts the exact frame length from R4 and holds a write to the low address byte so that it is sampled on the completion edge. It then checks that the pointer reads the old value plus one, not the written value. A second write, to the wire-mode register in the middle of the same frame, must also leave no trace when read back.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DMY, PH_DAT} phase_e;
  typedef enum logic [1:0] {RM_PLAIN, RM_FAST, RM_DUAL, RM_QUAD} rmode_e;

  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_RDAT  = 8'h0C;
  localparam logic [7:0] OFS_AB0   = 8'h10;
  localparam logic [7:0] OFS_AB1   = 8'h14;
  localparam logic [7:0] OFS_AB2   = 8'h18;
  localparam logic [7:0] OFS_AB3   = 8'hC8;
  localparam logic [7:0] OFS_OPC_A = 8'h2C;
  localparam logic [7:0] OFS_OPC_B = 8'h30;
  localparam logic [7:0] OFS_CFG   = 8'h60;
  localparam logic [7:0] OFS_WIRE  = 8'hCC;

  localparam logic [7:0] CMD_RD1   = 8'h81;
  localparam logic [7:0] OPC_PLAIN = 8'h03;

  // quad beats dual beats fast beats plain
  function automatic rmode_e pick_mode(input logic [3:0] wm, input logic fast);
    if (wm[2])      return RM_QUAD;
    else if (wm[0]) return RM_DUAL;
    else if (fast)  return RM_FAST;
    else            return RM_PLAIN;
  endfunction

  // log2 of the address lane count
  function automatic logic [1:0] addr_lsh(input rmode_e m, input logic [3:0] wm);
    if (m == RM_QUAD && wm[3])      return 2'd2;
    else if (m == RM_DUAL && wm[1]) return 2'd1;
    else                            return 2'd0;
  endfunction

  // log2 of the data lane count
  function automatic logic [1:0] data_lsh(input rmode_e m);
    case (m)
      RM_QUAD: return 2'd2;
      RM_DUAL: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sfr_regs.sv
module sfr_regs
  import sfr_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [7:0]        rx_byte,
  output logic              start,
  output logic [31:0]       cur_addr,
  output logic [3:0]        wire_mode,
  output logic              fast_en,
  output logic [7:0]        opc_a,
  output logic [7:0]        opc_b
);

  logic [31:0] ptr_q, ptr_n;
  logic [3:0]  wire_q, wire_n;
  logic        fast_q, fast_n;
  logic [7:0]  opa_q, opa_n, opb_q, opb_n, rd_q, rd_n;
  logic        wr_ok;

  assign wr_ok = we && !busy;
  assign start = wr_ok && (addr == REG_AW'(OFS_CMD)) && (wdata == CMD_RD1);

  always_comb begin
    ptr_n  = ptr_q;
    wire_n = wire_q;
    fast_n = fast_q;
    opa_n  = opa_q;
    opb_n  = opb_q;
    rd_n   = rd_q;
    if (done) begin
      ptr_n = ptr_q + 32'd1;
      rd_n  = rx_byte;
    end else if (wr_ok) begin
      if (addr == REG_AW'(OFS_AB0))   ptr_n[7:0]   = wdata;
      if (addr == REG_AW'(OFS_AB1))   ptr_n[15:8]  = wdata;
      if (addr == REG_AW'(OFS_AB2))   ptr_n[23:16] = wdata;
      if (addr == REG_AW'(OFS_AB3))   ptr_n[31:24] = wdata;
      if (addr == REG_AW'(OFS_WIRE))  wire_n       = wdata[3:0];
      if (addr == REG_AW'(OFS_CFG))   fast_n       = wdata[0];
      if (addr == REG_AW'(OFS_OPC_A)) opa_n        = wdata;
      if (addr == REG_AW'(OFS_OPC_B)) opb_n        = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wire_q <= '0;
      fast_q <= 1'b0;
      opa_q  <= '0;
      opb_q  <= '0;
      rd_q   <= '0;
    end else begin
      ptr_q  <= ptr_n;
      wire_q <= wire_n;
      fast_q <= fast_n;
      opa_q  <= opa_n;
      opb_q  <= opb_n;
      rd_q   <= rd_n;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == REG_AW'(OFS_CMD))   rdata = {7'd0, busy};
    if (addr == REG_AW'(OFS_RDAT))  rdata = rd_q;
    if (addr == REG_AW'(OFS_AB0))   rdata = ptr_q[7:0];
    if (addr == REG_AW'(OFS_AB1))   rdata = ptr_q[15:8];
    if (addr == REG_AW'(OFS_AB2))   rdata = ptr_q[23:16];
    if (addr == REG_AW'(OFS_AB3))   rdata = ptr_q[31:24];
    if (addr == REG_AW'(OFS_WIRE))  rdata = {4'd0, wire_q};
    if (addr == REG_AW'(OFS_CFG))   rdata = {7'd0, fast_q};
    if (addr == REG_AW'(OFS_OPC_A)) rdata = opa_q;
    if (addr == REG_AW'(OFS_OPC_B)) rdata = opb_q;
  end

  assign cur_addr  = ptr_q;
  assign wire_mode = wire_q;
  assign fast_en   = fast_q;
  assign opc_a     = opa_q;
  assign opc_b     = opb_q;

  // R9
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ptr_q == $past(ptr_q) + 32'd1);

  // R9
  byte_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rd_q == $past(rx_byte));

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && !done) |=> ($stable(ptr_q) && $stable(wire_q) && $stable(fast_q)));

endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
  import sfr_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_CLKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cur_addr,
  input  logic [3:0]  wire_mode,
  input  logic        fast_en,
  input  logic [7:0]  opc_a,
  input  logic [7:0]  opc_b,
  input  logic [3:0]  io_in,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rx_byte,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe
);

  localparam int TXW   = 8 + ADDR_BITS;
  localparam int CMAX  = (ADDR_BITS > DUMMY_CLKS) ? ADDR_BITS : DUMMY_CLKS;
  localparam int CNT_W = $clog2(CMAX + 1);

  phase_e           ph_q, ph_n;
  logic             busy_q, busy_n, h_q, h_n, dmy_q, dmy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [TXW-1:0]   tx_q, tx_n;
  logic [7:0]       rx_q, rx_n;
  logic [1:0]       als_q, als_n, dls_q, dls_n;
  rmode_e           mode_w;
  logic [7:0]       opc_w;
  logic             last_beat;

  assign mode_w = pick_mode(wire_mode, fast_en);

  always_comb begin
    case (mode_w)
      RM_PLAIN: opc_w = OPC_PLAIN;
      RM_QUAD:  opc_w = opc_b;
      default:  opc_w = opc_a;
    endcase
  end

  assign last_beat = (cnt_q == CNT_W'(1));

  always_comb begin
    ph_n   = ph_q;
    busy_n = busy_q;
    h_n    = h_q;
    dmy_n  = dmy_q;
    cnt_n  = cnt_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    als_n  = als_q;
    dls_n  = dls_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        h_n    = 1'b0;
        ph_n   = PH_OPC;
        cnt_n  = CNT_W'(8);
        tx_n   = {opc_w, cur_addr[ADDR_BITS-1:0]};
        als_n  = addr_lsh(mode_w, wire_mode);
        dls_n  = data_lsh(mode_w);
        dmy_n  = (mode_w != RM_PLAIN);
      end
    end else if (!h_q) begin
      h_n = 1'b1;
    end else begin
      h_n   = 1'b0;
      cnt_n = cnt_q - CNT_W'(1);
      case (ph_q)
        PH_OPC: begin
          tx_n = tx_q << 1;
          if (last_beat) begin
            ph_n  = PH_ADR;
            cnt_n = CNT_W'(ADDR_BITS) >> als_q;
          end
        end
        PH_ADR: begin
          tx_n = tx_q << (1 << als_q);
          if (last_beat) begin
            ph_n  = dmy_q ? PH_DMY : PH_DAT;
            cnt_n = dmy_q ? CNT_W'(DUMMY_CLKS) : (CNT_W'(8) >> dls_q);
          end
        end
        PH_DMY: begin
          if (last_beat) begin
            ph_n  = PH_DAT;
            cnt_n = CNT_W'(8) >> dls_q;
          end
        end
        default: begin
          case (dls_q)
            2'd0:    rx_n = {rx_q[6:0], io_in[1]};
            2'd1:    rx_n = {rx_q[5:0], io_in[1:0]};
            default: rx_n = {rx_q[3:0], io_in};
          endcase
          if (last_beat) begin
            busy_n = 1'b0;
            done   = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OPC;
      busy_q <= 1'b0;
      h_q    <= 1'b0;
      dmy_q  <= 1'b0;
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      als_q  <= '0;
      dls_q  <= '0;
    end else begin
      ph_q   <= ph_n;
      busy_q <= busy_n;
      h_q    <= h_n;
      dmy_q  <= dmy_n;
      cnt_q  <= cnt_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      als_q  <= als_n;
      dls_q  <= dls_n;
    end
  end

  always_comb begin
    io_out = 4'd0;
    io_oe  = 4'd0;
    if (busy_q && ph_q == PH_OPC) begin
      io_out = {3'd0, tx_q[TXW-1]};
      io_oe  = 4'b0001;
    end else if (busy_q && ph_q == PH_ADR) begin
      case (als_q)
        2'd0:    begin io_out = {3'd0, tx_q[TXW-1]};      io_oe = 4'b0001; end
        2'd1:    begin io_out = {2'd0, tx_q[TXW-1 -: 2]}; io_oe = 4'b0011; end
        default: begin io_out = tx_q[TXW-1 -: 4];         io_oe = 4'b1111; end
      endcase
    end
  end

  assign busy    = busy_q;
  assign rx_byte = rx_n;
  assign sck     = h_q;
  assign cs_n    = ~busy_q;

  // R4
  sck_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);

  // R3
  frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cs_n);

  // R4
  data_lanes_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (ph_q == PH_DAT || ph_q == PH_DMY)) |-> (io_oe == 4'd0));

endmodule

// File: rtl/sfr_byte_reader.sv
module sfr_byte_reader
  import sfr_pkg::*;
#(
  parameter bit ADDR_4B    = 1'b0,
  parameter int DUMMY_CLKS = 8,
  parameter int REG_AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);

  localparam int ADDR_BITS = ADDR_4B ? 32 : 24;

  logic        busy, done, start, fast_en;
  logic [7:0]  rx_byte, opc_a, opc_b;
  logic [31:0] cur_addr;
  logic [3:0]  wire_mode;

  sfr_regs #(.REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .start     (start),
    .cur_addr  (cur_addr),
    .wire_mode (wire_mode),
    .fast_en   (fast_en),
    .opc_a     (opc_a),
    .opc_b     (opc_b)
  );

  sfr_seq #(.ADDR_BITS(ADDR_BITS), .DUMMY_CLKS(DUMMY_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cur_addr  (cur_addr),
    .wire_mode (wire_mode),
    .fast_en   (fast_en),
    .opc_a     (opc_a),
    .opc_b     (opc_b),
    .io_in     (spi_io_in),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .io_out    (spi_io_out),
    .io_oe     (spi_io_oe)
  );

  // R4
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);

endmodule

// File: tb/sfr_byte_reader_test.sv
`timescale 1ns/1ps
module sfr_byte_reader_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_cs_n;
  logic [3:0] spi_io_out, spi_io_oe;
  logic [3:0] spi_io_in = 4'd0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sfr_byte_reader uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .spi_io_in(spi_io_in)
  );

  // ---------------- flash model ----------------
  int          m_al = 1, m_dl = 1, m_dummy = 0;
  int          beat = 0;
  logic [7:0]  cap_op = 8'h00;
  logic [31:0] cap_addr = 32'h0;

  function automatic logic [7:0] flash_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(negedge spi_cs_n) begin
    beat = 0;
    cap_op = 8'h00;
    cap_addr = 32'h0;
  end

  always @(posedge spi_sck) begin
    if (beat < 8) cap_op = {cap_op[6:0], spi_io_out[0]};
    else if (beat < 8 + 24 / m_al) begin
      case (m_al)
        1:       cap_addr = {cap_addr[30:0], spi_io_out[0]};
        2:       cap_addr = {cap_addr[29:0], spi_io_out[1:0]};
        default: cap_addr = {cap_addr[27:0], spi_io_out[3:0]};
      endcase
    end
    beat = beat + 1;
  end

  always @(negedge spi_sck) begin
    int dstart, k, sh;
    logic [7:0] d, v;
    dstart = 8 + 24 / m_al + m_dummy;
    if (beat >= dstart && beat < dstart + 8 / m_dl) begin
      k  = beat - dstart;
      sh = 8 - m_dl * (k + 1);
      d  = flash_byte(cap_addr);
      v  = (d >> sh) & 8'((1 << m_dl) - 1);
      if (m_dl == 1) spi_io_in = {2'b00, v[0], 1'b0};
      else           spi_io_in = v[3:0];
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    rd(8'h10, b0); rd(8'h14, b1); rd(8'h18, b2); rd(8'hC8, b3);
    v = {b3, b2, b1, b0};
  endtask

  // one frame: checks opcode, address, length, data and pointer advance
  task automatic do_read(input string req, input logic [7:0] exp_op,
                         input int al, input int dl, input int dmy);
    logic [31:0] base, after;
    logic [7:0]  b;
    int cyc, nbeats;
    rd32(base);
    m_al = al; m_dl = dl; m_dummy = dmy;
    nbeats = 8 + 24 / al + dmy + 8 / dl;
    wr(8'h00, 8'h81);
    reg_addr = 8'h00;
    #1 chk({req, " R3 status busy"}, {24'd0, reg_rdata}, 32'h01);
    cyc = 0;
    while (spi_cs_n == 1'b0 && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    chk({req, " R4 frame cycles"}, cyc, 2 * nbeats);
    chk({req, " opcode"}, {24'd0, cap_op}, {24'd0, exp_op});
    chk({req, " R2 address sent"}, cap_addr, {8'd0, base[23:0]});
    rd(8'h00, b);
    chk({req, " R3 status idle"}, {24'd0, b}, 32'h0);
    rd(8'h0C, b);
    chk({req, " R9 data byte"}, {24'd0, b}, {24'd0, flash_byte(base)});
    rd32(after);
    chk({req, " R9 pointer advance"}, after, base + 32'd1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] b;
    chk("R1 cs_n idle", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 sck idle", {31'd0, spi_sck}, 32'd0);
    chk("R1 oe idle", {28'd0, spi_io_oe}, 32'd0);
    foreach (b[i]) begin end
    rd(8'h00, b); chk("R1 cmd reg", {24'd0, b}, 0);
    rd(8'h0C, b); chk("R1 rdata reg", {24'd0, b}, 0);
    rd(8'h10, b); chk("R1 addr0 reg", {24'd0, b}, 0);
    rd(8'hCC, b); chk("R1 wire reg", {24'd0, b}, 0);
    rd(8'h60, b); chk("R1 cfg reg", {24'd0, b}, 0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(8'h10, 8'h12); wr(8'h14, 8'h34); wr(8'h18, 8'h56); wr(8'hC8, 8'hA7);
    rd32(v);
    chk("R2 pointer readback", v, 32'hA7563412);
    do_read("R5 plain first", 8'h03, 1, 1, 0);
    do_read("R5 plain second", 8'h03, 1, 1, 0);
  endtask

  task automatic t_fast();
    wr(8'h60, 8'h01); wr(8'h2C, 8'h0B);
    do_read("R6 fast", 8'h0B, 1, 1, 8);
  endtask

  task automatic t_dual();
    wr(8'h2C, 8'h3B); wr(8'hCC, 8'h01);
    do_read("R7 dual data", 8'h3B, 1, 2, 8);
    wr(8'hCC, 8'h03);
    do_read("R7 dual addr", 8'h3B, 2, 2, 8);
  endtask

  task automatic t_quad();
    wr(8'h30, 8'h6B); wr(8'hCC, 8'h04);
    do_read("R8 quad data", 8'h6B, 1, 4, 8);
    wr(8'hCC, 8'h0C);
    do_read("R8 quad addr", 8'h6B, 4, 4, 8);
    wr(8'hCC, 8'h05);
    do_read("R8 priority", 8'h6B, 1, 4, 8);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] b;
    wr(8'hCC, 8'h00); wr(8'h60, 8'h00);
    wr(8'h00, 8'h55);
    repeat (4) @(negedge clk);
    chk("R3 other code no frame", {31'd0, spi_cs_n}, 32'd1);
    rd(8'h00, b);
    chk("R3 other code status", {24'd0, b}, 0);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    wr(8'h10, 8'hFF); wr(8'h14, 8'hFF); wr(8'h18, 8'hFF); wr(8'hC8, 8'h00);
    do_read("R9 carry read", 8'h03, 1, 1, 0);
    rd32(v);
    chk("R9 carry into top byte", v, 32'h01000000);
  endtask

  task automatic t_collide();
    logic [31:0] base, v;
    logic [7:0]  b;
    int nbeats;
    wr(8'h10, 8'h40); wr(8'h14, 8'h00); wr(8'h18, 8'h00); wr(8'hC8, 8'h00);
    rd32(base);
    m_al = 1; m_dl = 1; m_dummy = 0;
    nbeats = 8 + 24 + 8;
    wr(8'h00, 8'h81);
    // mid-frame write to wire mode: must be dropped
    reg_we = 1'b1; reg_addr = 8'hCC; reg_wdata = 8'h04;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (2 * nbeats - 2) @(negedge clk);
    // sampled on the completion edge
    reg_we = 1'b1; reg_addr = 8'h10; reg_wdata = 8'hEE;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10 frame closed at completion edge", {31'd0, spi_cs_n}, 32'd1);
    rd32(v);
    chk("R10 increment wins over write", v, base + 32'd1);
    rd(8'hCC, b);
    chk("R10 mid-frame write dropped", {24'd0, b}, 0);
    rd(8'h0C, b);
    chk("R10 data byte", {24'd0, b}, {24'd0, flash_byte(base)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_fast();
    t_dual();
    t_quad();
    t_bad_cmd();
    t_carry();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule